// File: doc/BRIEF.md
# Debug Mailbox Handshake Controller

This block is a two-way mailbox between an external debugger port and an on-chip debug handler running as software. The debugger writes a receive data register and reads a transmit data register. The software side does the opposite: it reads the receive register and writes the transmit register. A 32-bit status word tells software the state of each side, so neither side reads stale data or overwrites unread data without it being noticed.

The four status flags sit in the top four bits of the word. Software can move them straight into its condition flags and branch on them. The flags are receive-ready, a sticky receive-overflow, a download branch flag that only the debugger sets, and transmit-ready. The lower 28 bits are always zero. Every flag and both data registers update on the rising clock edge after the access that changes them. The status word and the data outputs are combinational views of those registers.

Top module: `dbg_mailbox`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0x00000000 and both data outputs read zero.
- R2: Status layout: bit 31 is RX ready, bit 30 is RX overflow, bit 29 is the download flag, bit 28 is TX ready, and bits 27..0 always read zero.
- R3: A debugger receive write stores its data and sets RX ready. A software receive read that has no debugger write in the same cycle clears RX ready. The stored data is always visible on `sw_rx_data`.
- R4: A debugger receive write while RX ready is set, with no software read in that cycle, sets the overflow bit. The new data replaces the old and RX ready stays set.
- R5: A debugger receive write together with a software receive read in the same cycle raises no overflow. The new data is stored and RX ready ends set.
- R6: The overflow bit is sticky. A software status write with bit 30 = 0 clears it, and a write with bit 30 = 1 leaves it unchanged. A new overflow in the same cycle as a clear leaves the bit set.
- R7: Software status writes have no effect on bits 31, 29, 28 or 27..0.
- R8: A software transmit write stores its data on `dbg_tx_data` and clears TX ready. A debugger transmit read with no software write in that cycle sets TX ready. When both happen in the same cycle, TX ready ends cleared.
- R9: Each debugger receive write copies `dbg_dl_val` into the download flag. The flag holds its value at all other times, whatever software does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_rx_wr | input | 1 | Debugger writes the receive register this cycle |
| dbg_rx_data | input | 32 | Receive data from the debugger |
| dbg_dl_val | input | 1 | Download flag value, taken with each receive write |
| dbg_tx_rd | input | 1 | Debugger reads the transmit register this cycle |
| dbg_tx_data | output | 32 | Transmit register contents |
| sw_rx_rd | input | 1 | Software reads the receive register this cycle |
| sw_rx_data | output | 32 | Receive register contents |
| sw_tx_wr | input | 1 | Software writes the transmit register this cycle |
| sw_tx_wdata | input | 32 | Transmit data from software |
| sw_ctl_wr | input | 1 | Software writes the status word this cycle |
| sw_ctl_wdata | input | 32 | Status write data (only bit 30 acts) |
| sw_ctl_rdata | output | 32 | Status word |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a debugger receive write and a software receive read. The bench drives both strobes on one edge while RX ready is set and expects no overflow, the new data stored, and RX ready still set. The second pair is a new overflow and a software clear of that bit. The bench sets up a pending receive word, then fires a second debugger write together with a bit-30-zero status write, and expects the overflow bit to stay set. A random phase also lands these collisions often. A behavioural model judges every cycle of that phase.

// File: rtl/dbgmb_pkg.sv
// Package: shared widths, status-bit positions and the flag bundle for
// the debug mailbox. The flag positions are fixed because software
// loads the top four bits straight into its condition flags.
package dbgmb_pkg;
    localparam int unsigned STAT_W    = 32;
    localparam int unsigned BIT_RXRDY = 31;
    localparam int unsigned BIT_OVF   = 30;
    localparam int unsigned BIT_DL    = 29;
    localparam int unsigned BIT_TXRDY = 28;

    typedef struct packed {
        logic rx_rdy;
        logic ovf;
        logic dl;
        logic tx_rdy;
    } mb_flags_t;
endpackage

// File: rtl/dbgmb_rx_chan.sv
// Receive channel: holds the debugger-to-software data word, the RX
// ready flag and the sticky overflow flag.
// Assumes: at most one debugger write and one software read per cycle;
// ovf_clr is already decoded from a software status write.
module dbgmb_rx_chan #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    input  logic          ovf_clr,
    output logic [DW-1:0] rdata,
    output logic          rx_rdy,
    output logic          ovf
);
    logic          ovf_hit;
    logic [DW-1:0] data_q;

    // Overflow: new data arrives while unread data is pending.
    always_comb ovf_hit = wr && rx_rdy && !rd;

    // Data register: each debugger write replaces the contents.
    always_ff @(posedge clk) begin
        if (!rst_n)  data_q <= '0;
        else if (wr) data_q <= wdata;
    end

    // Ready flag: a write sets it, and a read alone clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)  rx_rdy <= 1'b0;
        else if (wr) rx_rdy <= 1'b1;
        else if (rd) rx_rdy <= 1'b0;
    end

    // Sticky overflow: a new hit wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (ovf_hit) ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    assign rdata = data_q;

    AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> rx_rdy); // R3
    AST_RX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> !rx_rdy); // R3
    AST_RX_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata == $past(wdata))); // R4
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && rx_rdy && !rd) |=> ovf); // R4
    AST_NO_OVF_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf && rd) |=> !ovf); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R6
endmodule

// File: rtl/dbgmb_tx_chan.sv
// Transmit channel: holds the software-to-debugger data word and the TX
// ready flag. Set means the debugger has taken the last word.
// Assumes: at most one software write and one debugger read per cycle.
module dbgmb_tx_chan #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    output logic          tx_rdy
);
    logic [DW-1:0] data_q;

    // Data register: loaded by each software write.
    always_ff @(posedge clk) begin
        if (!rst_n)  data_q <= '0;
        else if (wr) data_q <= wdata;
    end

    // Ready flag: a write clears it, and a debugger read alone sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)  tx_rdy <= 1'b0;
        else if (wr) tx_rdy <= 1'b0;
        else if (rd) tx_rdy <= 1'b1;
    end

    assign rdata = data_q;

    AST_TX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !tx_rdy); // R8
    AST_TX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> tx_rdy); // R8
    AST_TX_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata == $past(wdata))); // R8
endmodule

// File: rtl/dbgmb_status.sv
// Status word: holds the debugger-owned download flag and packs the four
// flags into the top bits of the word, with all lower bits at zero.
// Assumes: flag inputs come from the register outputs of the channels.
module dbgmb_status
    import dbgmb_pkg::*;
#(
    parameter int unsigned W = STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dl_wr,
    input  logic         dl_val,
    input  logic         rx_rdy,
    input  logic         ovf,
    input  logic         tx_rdy,
    output logic [W-1:0] word
);
    mb_flags_t flags;
    logic      dl_q;

    // Download flag: changes only with a debugger receive write.
    always_ff @(posedge clk) begin
        if (!rst_n)     dl_q <= 1'b0;
        else if (dl_wr) dl_q <= dl_val;
    end

    // Bundle the flags.
    always_comb begin
        flags.rx_rdy = rx_rdy;
        flags.ovf    = ovf;
        flags.dl     = dl_q;
        flags.tx_rdy = tx_rdy;
    end

    // Place each flag at its fixed bit and zero every other bit.
    always_comb begin
        word            = '0;
        word[BIT_RXRDY] = flags.rx_rdy;
        word[BIT_OVF]   = flags.ovf;
        word[BIT_DL]    = flags.dl;
        word[BIT_TXRDY] = flags.tx_rdy;
    end

    AST_DL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dl_wr |=> $stable(dl_q)); // R9
    AST_DL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dl_wr |=> (dl_q == $past(dl_val))); // R9
endmodule

// File: rtl/dbg_mailbox.sv
// Top: debug mailbox between a debugger data-register port and a
// software register port. It wires the RX and TX channels to the status
// packer and decodes the software overflow clear.
// Assumes: one clock domain; the debugger side is already synchronised.
module dbg_mailbox
    import dbgmb_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_rx_wr,
    input  logic [DW-1:0]     dbg_rx_data,
    input  logic              dbg_dl_val,
    input  logic              dbg_tx_rd,
    output logic [DW-1:0]     dbg_tx_data,
    input  logic              sw_rx_rd,
    output logic [DW-1:0]     sw_rx_data,
    input  logic              sw_tx_wr,
    input  logic [DW-1:0]     sw_tx_wdata,
    input  logic              sw_ctl_wr,
    input  logic [STAT_W-1:0] sw_ctl_wdata,
    output logic [STAT_W-1:0] sw_ctl_rdata
);
    logic rx_rdy, ovf, tx_rdy, ovf_clr;
    logic unused_ctl_bits;

    // Software clears the overflow flag by writing zero to its bit.
    always_comb ovf_clr = sw_ctl_wr && !sw_ctl_wdata[BIT_OVF];

    // The other status-write bits are ignored by definition.
    always_comb unused_ctl_bits = ^{sw_ctl_wdata[STAT_W-1:BIT_OVF+1],
                                    sw_ctl_wdata[BIT_OVF-1:0]};

    dbgmb_rx_chan #(.DW(DW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (dbg_rx_wr),
        .wdata   (dbg_rx_data),
        .rd      (sw_rx_rd),
        .ovf_clr (ovf_clr),
        .rdata   (sw_rx_data),
        .rx_rdy  (rx_rdy),
        .ovf     (ovf)
    );

    dbgmb_tx_chan #(.DW(DW)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (sw_tx_wr),
        .wdata  (sw_tx_wdata),
        .rd     (dbg_tx_rd),
        .rdata  (dbg_tx_data),
        .tx_rdy (tx_rdy)
    );

    dbgmb_status #(.W(STAT_W)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .dl_wr  (dbg_rx_wr),
        .dl_val (dbg_dl_val),
        .rx_rdy (rx_rdy),
        .ovf    (ovf),
        .tx_rdy (tx_rdy),
        .word   (sw_ctl_rdata)
    );

    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ctl_wr && !sw_ctl_wdata[BIT_OVF] && !(dbg_rx_wr && !sw_rx_rd))
        |=> !sw_ctl_rdata[BIT_OVF]); // R6
    AST_SW_NO_FLAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ctl_wr && !dbg_rx_wr && !sw_rx_rd && !sw_tx_wr && !dbg_tx_rd)
        |=> (sw_ctl_rdata[BIT_RXRDY] == $past(sw_ctl_rdata[BIT_RXRDY])) &&
            (sw_ctl_rdata[BIT_DL]    == $past(sw_ctl_rdata[BIT_DL])) &&
            (sw_ctl_rdata[BIT_TXRDY] == $past(sw_ctl_rdata[BIT_TXRDY]))); // R7
endmodule

// File: tb/test_dbg_mailbox.sv
`timescale 1ns/1ps
module test_dbg_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_rx_wr = 0, dbg_dl_val = 0, dbg_tx_rd = 0;
    logic        sw_rx_rd = 0, sw_tx_wr = 0, sw_ctl_wr = 0;
    logic [31:0] dbg_rx_data = 0, sw_tx_wdata = 0, sw_ctl_wdata = 0;
    logic [31:0] dbg_tx_data, sw_rx_data, sw_ctl_rdata;
    int total = 0, bad = 0;
    bit done = 0;

    // Reference model state
    bit m_rr, m_ov, m_dl, m_tr;
    logic [31:0] m_rxd, m_txd;

    always #2.5 clk = ~clk;

    dbg_mailbox i_dbg_mailbox (
        .clk(clk), .rst_n(rst_n),
        .dbg_rx_wr(dbg_rx_wr), .dbg_rx_data(dbg_rx_data), .dbg_dl_val(dbg_dl_val),
        .dbg_tx_rd(dbg_tx_rd), .dbg_tx_data(dbg_tx_data),
        .sw_rx_rd(sw_rx_rd), .sw_rx_data(sw_rx_data),
        .sw_tx_wr(sw_tx_wr), .sw_tx_wdata(sw_tx_wdata),
        .sw_ctl_wr(sw_ctl_wr), .sw_ctl_wdata(sw_ctl_wdata),
        .sw_ctl_rdata(sw_ctl_rdata));

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each edge, then compare just after it.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rr = 0; m_ov = 0; m_dl = 0; m_tr = 0; m_rxd = 0; m_txd = 0;
        end else begin
            if (dbg_rx_wr && m_rr && !sw_rx_rd) m_ov = 1;
            else if (sw_ctl_wr && sw_ctl_wdata[30] == 1'b0) m_ov = 0;
            if (dbg_rx_wr) begin m_rr = 1; m_rxd = dbg_rx_data; m_dl = dbg_dl_val; end
            else if (sw_rx_rd) m_rr = 0;
            if (sw_tx_wr) begin m_tr = 0; m_txd = sw_tx_wdata; end
            else if (dbg_tx_rd) m_tr = 1;
        end
        #1;
        chk({31'd0, sw_ctl_rdata[31]}, {31'd0, m_rr}, "R3 model rx ready");
        chk({31'd0, sw_ctl_rdata[30]}, {31'd0, m_ov}, "R6 model overflow");
        chk({31'd0, sw_ctl_rdata[29]}, {31'd0, m_dl}, "R9 model download flag");
        chk({31'd0, sw_ctl_rdata[28]}, {31'd0, m_tr}, "R8 model tx ready");
        chk({4'd0, sw_ctl_rdata[27:0]}, 32'd0, "R2 model low bits zero");
        chk(sw_rx_data, m_rxd, "R4 model rx data");
        chk(dbg_tx_data, m_txd, "R8 model tx data");
    end

    task automatic idle();
        dbg_rx_wr = 0; dbg_tx_rd = 0; sw_rx_rd = 0; sw_tx_wr = 0; sw_ctl_wr = 0;
    endtask

    // Drive one cycle of strobes, then return idle after the edge.
    task automatic op(input bit rxw, input logic [31:0] rxd, input bit dl,
                      input bit txr, input bit rxr, input bit txw,
                      input logic [31:0] txd, input bit cw, input logic [31:0] cd);
        @(negedge clk);
        dbg_rx_wr = rxw; dbg_rx_data = rxd; dbg_dl_val = dl; dbg_tx_rd = txr;
        sw_rx_rd = rxr; sw_tx_wr = txw; sw_tx_wdata = txd;
        sw_ctl_wr = cw; sw_ctl_wdata = cd;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sw_ctl_rdata, 32'h0, "R1 reset status");
        chk(sw_rx_data, 32'h0, "R1 reset rx data");
        chk(dbg_tx_data, 32'h0, "R1 reset tx data");
        rst_n = 1;
        @(negedge clk);
        // R3: receive write then software read
        op(1, 32'hA5A5_0001, 1, 0, 0, 0, 0, 0, 0);
        chk(sw_ctl_rdata, 32'hA000_0000, "R3 ready+dl after write");
        chk(sw_rx_data, 32'hA5A5_0001, "R3 rx data");
        op(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk(sw_ctl_rdata, 32'h2000_0000, "R3 ready clear after read, R9 dl holds");
        // R4: overwrite unread data
        op(1, 32'h1111_1111, 0, 0, 0, 0, 0, 0, 0);
        op(1, 32'h2222_2222, 0, 0, 0, 0, 0, 0, 0);
        chk(sw_ctl_rdata, 32'hC000_0000, "R4 overflow and ready");
        chk(sw_rx_data, 32'h2222_2222, "R4 new data replaces");
        // R6: writing 1 keeps, writing 0 clears
        op(0, 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
        chk(sw_ctl_rdata, 32'hC000_0000, "R6 write one keeps, R7 others ignored");
        op(0, 0, 0, 0, 0, 0, 0, 1, 32'h0000_0000);
        chk(sw_ctl_rdata, 32'h8000_0000, "R6 write zero clears");
        // R6: overflow in the same cycle as a clear wins
        op(1, 32'h3333_3333, 1, 0, 0, 0, 0, 1, 32'h0);
        chk(sw_ctl_rdata, 32'hE000_0000, "R6 overflow beats clear");
        op(0, 0, 0, 0, 0, 0, 0, 1, 32'h0);
        // R5: write and read together
        op(1, 32'h4444_4444, 0, 0, 1, 0, 0, 0, 0);
        chk(sw_ctl_rdata, 32'h8000_0000, "R5 no overflow, ready set");
        chk(sw_rx_data, 32'h4444_4444, "R5 new data");
        // R7: software cannot write flags
        op(0, 0, 0, 0, 1, 0, 0, 0, 0);
        op(0, 0, 0, 0, 0, 0, 0, 1, 32'hBFFF_FFFF);
        chk(sw_ctl_rdata, 32'h0000_0000, "R7 flags not writable");
        // R8: transmit handshake
        op(0, 0, 0, 0, 0, 1, 32'hCAFE_0008, 0, 0);
        chk(dbg_tx_data, 32'hCAFE_0008, "R8 tx data");
        chk(sw_ctl_rdata, 32'h0000_0000, "R8 tx ready cleared");
        op(0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk(sw_ctl_rdata, 32'h1000_0000, "R8 tx ready after debugger read");
        op(0, 0, 0, 1, 0, 1, 32'h0BAD_0008, 0, 0);
        chk(sw_ctl_rdata, 32'h0000_0000, "R8 write wins on collision");
        // R9: dl set then cleared by debugger writes
        op(1, 32'h5, 1, 0, 0, 0, 0, 1, 32'h0);
        chk({31'd0, sw_ctl_rdata[29]}, 32'd1, "R9 dl set");
        op(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk({31'd0, sw_ctl_rdata[29]}, 32'd1, "R9 dl holds");
        op(1, 32'h6, 0, 0, 1, 0, 0, 0, 0);
        chk({31'd0, sw_ctl_rdata[29]}, 32'd0, "R9 dl cleared");
        // Random phase, model-checked every cycle
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            dbg_rx_wr = $urandom_range(0, 1);
            dbg_rx_data = $urandom;
            dbg_dl_val = $urandom_range(0, 1);
            dbg_tx_rd = $urandom_range(0, 1);
            sw_rx_rd = $urandom_range(0, 1);
            sw_tx_wr = $urandom_range(0, 1);
            sw_tx_wdata = $urandom;
            sw_ctl_wr = ($urandom_range(0, 3) == 0);
            sw_ctl_wdata = $urandom;
        end
        @(negedge clk);
        idle();
        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule